// File: doc/BRIEF.md
# Indexed Indirect Effective-Address Unit

This unit turns a 32-bit instruction word into the address of its operand. The low half of the word is a 16-bit base field. Bit 16 requests indirection, bits 17 to 19 choose an index source, and the top twelve bits carry the operation code. The base is added to the chosen index value with 16-bit wraparound. If indirection is requested, the sum becomes a memory address. The unit reads that word over a request/acknowledge port and treats it as a new address word with the same field layout. It repeats this, applying indexing again at every level, until a word arrives without the indirect bit.

A control pipeline asserts `start` with the instruction. When the result is ready, the unit returns a one-cycle `done` pulse with the effective address and three flags. The immediate flag means the base field itself is the signed operand. The marker flag means a fetched address word carried a set marker bit, so an interrupt must be raised before the operand fetch. The depth-error flag means the chain of indirection went past a parameterised limit and was cut off.

Top module: `ea_unit`

## Requirements
- R1: While reset is held and just after it, `done`, `busy`, `mem_req`, `imm`, `mark_hit` and `depth_err` are low.
- R2: Field positions are: base = bits 15:0, indirect = bit 16, index select = bits 19:17, immediate = bit 31. With immediate, indirect and index select all zero, `ea` equals the base field.
- R3: Index select 1 adds `acc_val`. Index select k in 2..7 adds `idx_bank[(k-2)*16 +: 16]`. Index select 0 adds nothing.
- R4: The base and the index value are added in two's complement, modulo 2^16.
- R5: When instruction bit 31 is set, the unit makes no memory request. It ignores the indirect and index fields, returns `ea` equal to the raw base field, and sets `imm`.
- R6: An indirect level drives `mem_req` high with `mem_addr` set to the indexed sum. Both stay unchanged until `mem_ack`. The returned word's bits 15:0, 16 and 19:17 are then used as the next base, indirect and index fields, and its bits 31:20 are ignored.
- R7: `mark_hit` is high in a result if either bit of `mem_mark` was set on any word fetched for that instruction. It is low for an instruction that fetched no marked word.
- R8: Up to `MAX_LEVELS` fetches complete normally. If the word returned by fetch number `MAX_LEVELS` still requests indirection, the unit finishes with `depth_err` high and `ea` equal to the address it would have fetched next.
- R9: `busy` is high from the cycle after `start` is accepted until the result is returned. While `busy` is high, `start` is ignored and `mem_req` is low whenever the unit is idle.
- R10: `done` is a single-cycle pulse. It rises two clock edges after the edge that accepts `start`, plus L+2 edges for each fetch whose acknowledge arrives L cycles after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin computing an address for `instr` |
| instr | input | 32 | Instruction word |
| acc_val | input | 16 | Accumulator value, index source 1 |
| idx_bank | input | 96 | Index sources 2..7, 16 bits each, source 2 lowest |
| mem_req | output | 1 | Address-word read request |
| mem_addr | output | 16 | Read address |
| mem_ack | input | 1 | Read data valid, ends the request |
| mem_rdata | input | 32 | Fetched address word |
| mem_mark | input | 2 | Marker bits of the fetched word |
| busy | output | 1 | Computation in progress |
| done | output | 1 | Result valid pulse |
| ea | output | 16 | Effective address or immediate operand |
| imm | output | 1 | Result is an immediate operand |
| mark_hit | output | 1 | A fetched address word was marked |
| depth_err | output | 1 | Indirection limit exceeded |

## Verification
Several properties are checked on every cycle. A read request must stay steady until it is acknowledged. `done` must last one cycle, and nothing is requested while the unit is idle. Direct and immediate instructions must return their base field two edges after acceptance. A depth error may appear only after exactly the limit of fetches. Other behaviours depend on memory contents, so only the bench scenarios can show them. These are the walk through multi-level chains with indexing at each level, the marker accumulating across a chain and clearing for the next instruction, wraparound with negative index values, the limit being reached exactly without error, and a `start` pulse arriving mid-chain being ignored.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int ADDR_W = 16;
  localparam int XSEL_W = 3;
  localparam int OP_W   = 12;
  localparam int WORD_W = ADDR_W + 1 + XSEL_W + OP_W;
  localparam int NSRC   = 2 ** XSEL_W;   // selector codes, code 0 = none
  localparam int NBANK  = NSRC - 2;      // sources beyond the accumulator

  typedef struct packed {
    logic [OP_W-1:0]   op;
    logic [XSEL_W-1:0] xsel;
    logic              ind;
    logic [ADDR_W-1:0] base;
  } ea_word_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CALC  = 2'd1,
    ST_FETCH = 2'd2
  } ea_state_e;
endpackage

// File: rtl/ea_index_add.sv
module ea_index_add
  import ea_pkg::*;
(
  input  logic [ADDR_W-1:0]       base,
  input  logic [XSEL_W-1:0]       xsel,
  input  logic [ADDR_W-1:0]       acc_val,
  input  logic [NBANK*ADDR_W-1:0] idx_bank,
  output logic [ADDR_W-1:0]       sum
);
  logic [ADDR_W-1:0] src [NSRC];

  assign src[0] = '0;
  assign src[1] = acc_val;

  genvar k;
  generate
    for (k = 2; k < NSRC; k++) begin : g_src
      assign src[k] = idx_bank[(k-2)*ADDR_W +: ADDR_W];
    end
  endgenerate

  // two's complement add, carry out discarded
  assign sum = base + src[xsel];
endmodule

// File: rtl/ea_seq.sv
module ea_seq
  import ea_pkg::*;
#(
  parameter int MAX_LEVELS = 8,
  localparam int DW = $clog2(MAX_LEVELS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] in_base,
  input  logic [XSEL_W-1:0] in_xsel,
  input  logic              in_ind,
  input  logic              in_imm,
  input  logic [ADDR_W-1:0] sum,
  output logic [ADDR_W-1:0] cur_base,
  output logic [XSEL_W-1:0] cur_xsel,
  input  logic              mem_ack,
  input  logic [ADDR_W-1:0] rd_base,
  input  logic [XSEL_W-1:0] rd_xsel,
  input  logic              rd_ind,
  input  logic              rd_mark,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] ea,
  output logic              imm,
  output logic              mark_hit,
  output logic              depth_err
);
  ea_state_e         state_q, state_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [XSEL_W-1:0] xsel_q, xsel_d;
  logic              ind_q, ind_d;
  logic              immf_q, immf_d;
  logic              mark_q, mark_d;
  logic [DW-1:0]     lvl_q, lvl_d;
  logic              word_en;
  logic [ADDR_W-1:0] addr_q;
  logic              addr_en;
  logic              done_q, done_d;
  logic [ADDR_W-1:0] ea_q, ea_d;
  logic              imm_q, imm_d, mhit_q, mhit_d, err_q, err_d;

  // next-state logic
  always_comb begin
    state_d = state_q;
    base_d  = base_q;
    xsel_d  = xsel_q;
    ind_d   = ind_q;
    immf_d  = immf_q;
    mark_d  = mark_q;
    lvl_d   = lvl_q;
    word_en = 1'b0;
    addr_en = 1'b0;
    done_d  = 1'b0;
    ea_d    = ea_q;
    imm_d   = imm_q;
    mhit_d  = mhit_q;
    err_d   = err_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_CALC;
          base_d  = in_base;
          xsel_d  = in_xsel;
          ind_d   = in_ind;
          immf_d  = in_imm;
          mark_d  = 1'b0;
          lvl_d   = '0;
          word_en = 1'b1;
        end
      end
      ST_CALC: begin
        if (immf_q) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          ea_d    = base_q;
          imm_d   = 1'b1;
          mhit_d  = 1'b0;
          err_d   = 1'b0;
        end else if (!ind_q || lvl_q == DW'(MAX_LEVELS)) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          ea_d    = sum;
          imm_d   = 1'b0;
          mhit_d  = mark_q;
          err_d   = ind_q;
        end else begin
          state_d = ST_FETCH;
          addr_en = 1'b1;
        end
      end
      ST_FETCH: begin
        if (mem_ack) begin
          state_d = ST_CALC;
          base_d  = rd_base;
          xsel_d  = rd_xsel;
          ind_d   = rd_ind;
          mark_d  = mark_q | rd_mark;
          lvl_d   = lvl_q + DW'(1);
          word_en = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      xsel_q <= '0;
      ind_q  <= 1'b0;
      immf_q <= 1'b0;
      mark_q <= 1'b0;
      lvl_q  <= '0;
    end else if (word_en) begin
      base_q <= base_d;
      xsel_q <= xsel_d;
      ind_q  <= ind_d;
      immf_q <= immf_d;
      mark_q <= mark_d;
      lvl_q  <= lvl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea_q   <= '0;
      imm_q  <= 1'b0;
      mhit_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (done_d) begin
      ea_q   <= ea_d;
      imm_q  <= imm_d;
      mhit_q <= mhit_d;
      err_q  <= err_d;
    end
  end

  assign cur_base  = base_q;
  assign cur_xsel  = xsel_q;
  assign mem_req   = (state_q == ST_FETCH);
  assign mem_addr  = addr_q;
  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign ea        = ea_q;
  assign imm       = imm_q;
  assign mark_hit  = mhit_q;
  assign depth_err = err_q;
endmodule

// File: rtl/ea_unit.sv
module ea_unit
  import ea_pkg::*;
#(
  parameter int MAX_LEVELS = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [WORD_W-1:0]       instr,
  input  logic [ADDR_W-1:0]       acc_val,
  input  logic [NBANK*ADDR_W-1:0] idx_bank,
  output logic                    mem_req,
  output logic [ADDR_W-1:0]       mem_addr,
  input  logic                    mem_ack,
  input  logic [WORD_W-1:0]       mem_rdata,
  input  logic [1:0]              mem_mark,
  output logic                    busy,
  output logic                    done,
  output logic [ADDR_W-1:0]       ea,
  output logic                    imm,
  output logic                    mark_hit,
  output logic                    depth_err
);
  ea_word_t          iw, rw;
  logic              rst_meta_n, rst_sync_n;
  logic [ADDR_W-1:0] cur_base, sum;
  logic [XSEL_W-1:0] cur_xsel;
  logic              unused_opbits;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  assign iw = instr;
  assign rw = mem_rdata;
  assign unused_opbits = ^{iw.op[OP_W-2:0], rw.op};

  ea_index_add u_add (
    .base     (cur_base),
    .xsel     (cur_xsel),
    .acc_val  (acc_val),
    .idx_bank (idx_bank),
    .sum      (sum)
  );

  ea_seq #(.MAX_LEVELS(MAX_LEVELS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start     (start),
    .in_base   (iw.base),
    .in_xsel   (iw.xsel),
    .in_ind    (iw.ind),
    .in_imm    (iw.op[OP_W-1]),
    .sum       (sum),
    .cur_base  (cur_base),
    .cur_xsel  (cur_xsel),
    .mem_ack   (mem_ack),
    .rd_base   (rw.base),
    .rd_xsel   (rw.xsel),
    .rd_ind    (rw.ind),
    .rd_mark   (|mem_mark),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .busy      (busy),
    .done      (done),
    .ea        (ea),
    .imm       (imm),
    .mark_hit  (mark_hit),
    .depth_err (depth_err)
  );
endmodule

// File: rtl/ea_chk.sv
module ea_chk #(
  parameter int MAX_LEVELS = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [31:0] instr,
  input logic        busy,
  input logic        mem_req,
  input logic        mem_ack,
  input logic [15:0] mem_addr,
  input logic        done,
  input logic        imm,
  input logic [15:0] ea,
  input logic        depth_err
);
  localparam int CW = $clog2(MAX_LEVELS + 2);
  logic [CW-1:0] fetches;
  logic          unused_chk;

  assign unused_chk = ^instr[30:20];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 fetches <= '0;
    else if (start && !busy)    fetches <= '0;
    else if (mem_req && mem_ack) fetches <= fetches + CW'(1);
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr)); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req); // R9

  AST_DIRECT_EA: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && !instr[31] && !instr[16] && instr[19:17] == 3'd0
    |=> ##1 (done && !imm && ea == $past(instr[15:0], 2))); // R2

  AST_IMM_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && instr[31]
    |=> ##1 (done && imm && ea == $past(instr[15:0], 2))); // R5

  AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fetches <= CW'(MAX_LEVELS)); // R8

  AST_DEPTH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    done && depth_err |-> fetches == CW'(MAX_LEVELS)); // R8
endmodule

bind ea_unit ea_chk #(.MAX_LEVELS(MAX_LEVELS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .instr     (instr),
  .busy      (busy),
  .mem_req   (mem_req),
  .mem_ack   (mem_ack),
  .mem_addr  (mem_addr),
  .done      (done),
  .imm       (imm),
  .ea        (ea),
  .depth_err (depth_err)
);

// File: tb/sim_ea_unit.sv
module sim_ea_unit;
  localparam int MAXL = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] instr = '0;
  logic [15:0] acc_val = 16'h0100;
  logic [95:0] idx_bank;
  logic        mem_req, mem_ack = 1'b0;
  logic [15:0] mem_addr;
  logic [31:0] mem_rdata = '0;
  logic [1:0]  mem_mark = '0;
  logic        busy, done, imm, mark_hit, depth_err;
  logic [15:0] ea;

  int vectors = 0;
  int fails = 0;
  int mem_lat = 0;
  int wcnt = 0;
  int acks = 0;
  bit finished = 0;
  logic [33:0] mem [int];
  logic [15:0] addr_q [$];

  ea_unit #(.MAX_LEVELS(MAXL)) u0 (.*);

  always #2 clk = ~clk;

  initial begin
    idx_bank[15:0]  = 16'h2000; // X=2
    idx_bank[31:16] = 16'h3000; // X=3
    idx_bank[47:32] = 16'h4000; // X=4
    idx_bank[63:48] = 16'hFFF0; // X=5, negative
    idx_bank[79:64] = 16'h6000; // X=6
    idx_bank[95:80] = 16'h2000; // X=7
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit im, input bit ind,
                                     input int x, input logic [15:0] m);
    return {im, 11'h5A5, 3'(x), ind, m};
  endfunction

  function automatic logic [15:0] xval(input logic [2:0] x);
    if (x == 3'd0) return 16'h0000;
    if (x == 3'd1) return acc_val;
    return idx_bank[(int'(x)-2)*16 +: 16];
  endfunction

  // memory responder with programmable latency
  initial begin
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
        if (wcnt == mem_lat) begin
          logic [33:0] d;
          logic [15:0] ex;
          d = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 34'h0;
          ex = (addr_q.size() > 0) ? addr_q.pop_front() : 16'hxxxx;
          chk(mem_addr === ex, "R6", "read address", mem_addr, ex);
          mem_rdata = d[31:0];
          mem_mark  = d[33:32];
          mem_ack   = 1'b1;
          acks++;
          wcnt = 0;
        end else wcnt++;
      end
    end
  end

  task automatic run(input logic [31:0] w, input int lat, input bit inject,
                     input string req);
    logic [31:0] cw;
    logic [15:0] e_ea, a;
    bit e_imm, e_mk, e_err;
    int n, e_cyc, k;
    logic [33:0] d;
    cw = w; n = 0; e_mk = 0; e_err = 0; e_imm = 0;
    addr_q.delete();
    if (w[31]) begin
      e_imm = 1; e_ea = w[15:0];
    end else begin
      forever begin
        a = cw[15:0] + xval(cw[19:17]);
        if (!cw[16]) begin e_ea = a; break; end
        if (n == MAXL) begin e_err = 1; e_ea = a; break; end
        addr_q.push_back(a);
        d = mem.exists(int'(a)) ? mem[int'(a)] : 34'h0;
        e_mk = e_mk | (|d[33:32]);
        cw = d[31:0];
        n++;
      end
    end
    e_cyc = 2 + n * (lat + 2);
    mem_lat = lat; acks = 0; wcnt = 0;
    @(negedge clk);
    start = 1'b1; instr = w;
    k = 0;
    while (!done && k < 200) begin
      @(negedge clk);
      k++;
      if (k == 1) begin
        start = 1'b0;
        chk(busy === 1'b1, "R9", "busy after accept", busy, 1);
      end
      if (inject && k == 3) begin
        start = 1'b1; instr = mk(1, 0, 0, 16'hDEAD);
      end
      if (inject && k == 4) start = 1'b0;
    end
    chk(k == e_cyc, "R10", "done latency", k, e_cyc);
    chk(ea === e_ea, req, "ea", ea, e_ea);
    chk(imm === e_imm, "R5", "imm flag", imm, e_imm);
    chk(mark_hit === e_mk, "R7", "marker flag", mark_hit, e_mk);
    chk(depth_err === e_err, "R8", "depth error", depth_err, e_err);
    chk(acks == n, "R6", "fetch count", acks, n);
    chk(busy === 1'b0, "R9", "idle at done", busy, 0);
    @(negedge clk);
    chk(done === 1'b0, "R10", "done pulse width", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(done === 0 && busy === 0 && mem_req === 0, "R1", "outputs in reset",
        {done, busy, mem_req}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk({done, busy, mem_req, imm, mark_hit, depth_err} === 6'b0, "R1",
        "outputs after reset", {done, busy, mem_req, imm, mark_hit, depth_err}, 0);

    run(mk(0, 0, 0, 16'h1234), 0, 0, "R2");
    run(mk(0, 0, 1, 16'h0010), 0, 0, "R3");
    run(mk(0, 0, 4, 16'h0002), 0, 0, "R3");
    run(mk(0, 0, 5, 16'h0008), 0, 0, "R4");
    run(mk(0, 0, 7, 16'hF000), 0, 0, "R4");
    run(mk(1, 1, 3, 16'h8001), 0, 0, "R5");

    mem[32'h2040] = {2'b00, mk(1, 0, 0, 16'h0777)};
    run(mk(0, 1, 2, 16'h0040), 2, 0, "R6");

    mem[32'h0100] = {2'b00, mk(0, 1, 1, 16'h0200)};
    mem[32'h0300] = {2'b10, mk(0, 1, 0, 16'h0400)};
    mem[32'h0400] = {2'b00, mk(0, 0, 6, 16'h0005)};
    run(mk(0, 1, 0, 16'h0100), 1, 0, "R7");
    run(mk(0, 0, 0, 16'h0042), 0, 0, "R7");

    mem[32'h0500] = {2'b01, mk(0, 1, 0, 16'h0500)};
    run(mk(0, 1, 0, 16'h0500), 0, 0, "R8");

    for (int i = 0; i < 7; i++)
      mem[32'h0600 + i] = {2'b00, mk(0, 1, 0, 16'h0601 + 16'(i))};
    mem[32'h0607] = {2'b00, mk(0, 0, 0, 16'h0ABC)};
    run(mk(0, 1, 0, 16'h0600), 0, 0, "R8");

    mem[32'h3050] = {2'b00, mk(0, 0, 0, 16'h0123)};
    run(mk(0, 1, 3, 16'h0050), 3, 1, "R9");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      vectors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule